// File: doc/BRIEF.md
# Asynchronous static RAM bridge

This block lets an on-chip request bus read and write an external asynchronous static RAM of 32768 bytes. A client presents a request with a write flag, a 15-bit byte address and write data, and holds it until the bridge is ready. The bridge then sequences the RAM's active-low select, write strobe and output enable, and drives the bidirectional data pins through a separate output value and drive-enable pair. A read returns its byte with a one-cycle valid pulse. A write finishes with a one-cycle done pulse.

Every analog timing minimum is given in nanoseconds as a parameter, together with the clock period. The bridge turns each minimum into a whole number of clock cycles by rounding up, with a floor of one cycle. Access waits, write pulses and the bus release after a read are all counted in cycles. Whenever no access is in progress, the RAM is deselected, which keeps it in standby, and the data pins are released.

Top module: `sram_bridge`

## Requirements
- R1: Out of reset, and in every cycle where `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R2: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with a stable address for RD_CYC = ceil(max(access, read cycle) / period) cycles. It samples `mem_dq_in` on the clock edge that ends the last of those cycles. With the default values (4 ns clock), RD_CYC is 3.
- R3: `rd_valid` is high for exactly one cycle, the cycle right after the sampling edge, and `rd_data` then holds the sampled byte. It is seen RD_CYC+1 cycles after the accepting edge.
- R4: A write holds `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 with `mem_dq_oe`=1. Address and data stay constant for exactly WR_CYC = ceil(max(write pulse, write cycle, data setup) / period) cycles. With the default values, WR_CYC is 3.
- R5: `mem_we_n` and `mem_cs_n` rise together. `mem_dq_oe` stays 1 for one further cycle, and `wr_done` pulses in that cycle, WR_CYC+1 cycles after the accepting edge.
- R6: After `mem_oe_n` was last 0, at least TURN_CYC = ceil(high-impedance time / period) cycles pass with `mem_oe_n`=1 and `mem_dq_oe`=0 before `mem_dq_oe` rises. With the default values, TURN_CYC is 2.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance and remains 0 until the access and its recovery end. A request held during that time runs exactly once, after the current one.
- R8: `mem_dq_oe` is never 1 in a cycle where `mem_cs_n`=0 and `mem_oe_n`=0.
- R9: Each phase counter loaded with N-1 runs down by one per cycle, so each phase lasts N cycles with N at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Bridge idle, request taken on this edge |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Read data |
| wr_done | output | 1 | One-cycle write-complete strobe |
| mem_addr | output | 15 | RAM address pins |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Value seen on the data pins |

## Verification
The RAM model returns valid data only once the read has been enabled for RD_CYC cycles, and a fixed filler value before that. A capture made one edge early therefore shows up as wrong data. The stimulus mixes reads of never-written bytes (which return an address-derived default), write-then-read pairs at the lowest and highest address, and seeded random sequences over a small address pool, so locations are rewritten and read back often. Back-to-back read/write alternations with no idle gap test the bus release after a read and the holding of a pending request. Random idle gaps test the standby state between accesses.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_RREL,
      ST_WRITE,
      ST_WHOLD
   } bridge_state_t;

   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned period_ns);
      int unsigned c;
      c = (t_ns + period_ns - 1) / period_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int unsigned MAX_CYC = 4,
   localparam int unsigned CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   generate
      if (MAX_CYC <= 1) begin : g_single
         // every phase is one cycle: nothing to count
         logic unused_in;
         assign unused_in = ^{load, load_val, clk, rst_n};
         assign done      = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (load)          cnt <= load_val;
            else if (cnt != '0)     cnt <= cnt - 1'b1;
         end

         assign done = (cnt == '0);

         assert_timer_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
      end
   endgenerate

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= dq_in;
      end
   end

   assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
   import sram_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned T_ACCESS_NS   = 10,
   parameter int unsigned T_RCYCLE_NS   = 10,
   parameter int unsigned T_WPULSE_NS   = 9,
   parameter int unsigned T_WCYCLE_NS   = 10,
   parameter int unsigned T_DSETUP_NS   = 6,
   parameter int unsigned T_HIZ_NS      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              wr_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned RD_CYC   = ns_to_cycles(umax(T_ACCESS_NS, T_RCYCLE_NS), CLK_PERIOD_NS);
   localparam int unsigned WR_CYC   = ns_to_cycles(umax(umax(T_WPULSE_NS, T_WCYCLE_NS), T_DSETUP_NS),
                                                   CLK_PERIOD_NS);
   localparam int unsigned TURN_CYC = ns_to_cycles(T_HIZ_NS, CLK_PERIOD_NS);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WR_CYC), TURN_CYC);
   localparam int unsigned CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_bridge: address and data widths must be non-zero");
      end
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("sram_bridge: clock period must be non-zero");
      end
      if (TURN_CYC > 200) begin : g_bad_turn
         $error("sram_bridge: bus release window too long for the guard counter");
      end
   endgenerate

   bridge_state_t state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              t_load;
   logic [CW-1:0]     t_val;
   logic              t_done;
   logic              cap_en;

   // phase timer loads
   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      if (state == ST_IDLE && req_valid) begin
         t_load = 1'b1;
         t_val  = req_write ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      end else if (state == ST_READ && t_done) begin
         t_load = 1'b1;
         t_val  = CW'(TURN_CYC - 1);
      end
   end

   sram_phase_timer #(.MAX_CYC(MAX_CYC)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         wr_done <= 1'b0;
      end else begin
         wr_done <= (state == ST_WRITE) && t_done;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               state   <= req_write ? ST_WRITE : ST_READ;
            end
            ST_READ:  if (t_done) state <= ST_RREL;
            ST_RREL:  if (t_done) state <= ST_IDLE;
            ST_WRITE: if (t_done) state <= ST_WHOLD;
            ST_WHOLD: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign cap_en = (state == ST_READ) && t_done;

   sram_read_capture #(.DATA_W(DATA_W)) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (cap_en),
      .dq_in    (mem_dq_in),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // pin decode straight from the state register
   assign req_ready  = (state == ST_IDLE);
   assign mem_cs_n   = !((state == ST_READ) || (state == ST_WRITE));
   assign mem_oe_n   = (state != ST_READ);
   assign mem_we_n   = (state != ST_WRITE);
   assign mem_dq_oe  = (state == ST_WRITE) || (state == ST_WHOLD);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   // cycles since the RAM outputs were last enabled, for the release check
   logic [7:0] oe_gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              oe_gap <= 8'd255;
      else if (!mem_oe_n)      oe_gap <= 8'd0;
      else if (oe_gap != 8'd255) oe_gap <= oe_gap + 8'd1;
   end

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   assert_rd_from_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_oe_n));

   assert_wr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && mem_oe_n && !mem_cs_n));

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && mem_cs_n && $stable(mem_dq_out)));

   assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_gap >= 8'(TURN_CYC)));

   assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_cs_n && !mem_oe_n));

endmodule

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;

   localparam int PERIOD = 4;

   function automatic int ceil_div(input int t, input int p);
      int c;
      c = (t + p - 1) / p;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int RD_CYC   = ceil_div(10, PERIOD);
   localparam int WR_CYC   = ceil_div(10, PERIOD);
   localparam int TURN_CYC = ceil_div(8, PERIOD);

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [14:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, rd_valid, wr_done;
   logic [7:0]  rd_data;
   logic [14:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #(PERIOD/2) clk = ~clk;

   sram_bridge i_sram_bridge (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] init_byte(input logic [14:0] a);
      return a[7:0] ^ a[14:7] ^ 8'h5A;
   endfunction

   function automatic logic [14:0] pick_addr(input int k);
      if (k == 14) return 15'h0000;
      if (k == 15) return 15'h7FFF;
      return 15'((k * 1021 + 37) & 32'h7FFF);
   endfunction

   // RAM model plus pin-level monitors
   logic [7:0]  mem_model [int];
   logic [7:0]  exp_mem [int];
   int          rd_age = 0;
   int          wlen = 0;
   logic [14:0] wa;
   logic [7:0]  wd;
   int          hi_cnt = 1000;
   bit          prev_dq_oe = 0;
   bit          prev_cs_low = 0;
   logic [14:0] prev_addr;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ready)  // R1 standby while idle
            check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1",
                  {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
         // R8 no drive while RAM outputs enabled
         check(!(mem_dq_oe && !mem_cs_n && !mem_oe_n), "R8", mem_dq_oe, 0);
         // R2 address stable while selected
         if (!mem_cs_n && prev_cs_low) check(mem_addr == prev_addr, "R2", mem_addr, prev_addr);
         // read model: valid only after RD_CYC enabled cycles
         if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age++; else rd_age = 0;
         if (rd_age >= RD_CYC)
            mem_dq_in <= mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : init_byte(mem_addr);
         else
            mem_dq_in <= 8'hEE;
         // write model
         if (!mem_cs_n && !mem_we_n) begin
            if (wlen > 0) check(mem_dq_out == wd && mem_addr == wa, "R4", mem_dq_out, wd);
            check(mem_dq_oe && mem_oe_n, "R4", {mem_dq_oe, mem_oe_n}, 2'b11);
            wlen++;
            wa = mem_addr;
            wd = mem_dq_out;
         end else if (wlen > 0) begin
            check(wlen == WR_CYC, "R4", wlen, WR_CYC);
            check(mem_dq_oe && mem_cs_n && mem_dq_out == wd, "R5", mem_dq_oe, 1);
            mem_model[int'(wa)] = wd;
            wlen = 0;
         end
         // R6 bus release after read
         if (mem_dq_oe && !prev_dq_oe) check(hi_cnt >= TURN_CYC, "R6", hi_cnt, TURN_CYC);
         if (!mem_oe_n) hi_cnt = 0;
         else if (!mem_dq_oe && hi_cnt < 1000) hi_cnt++;
         prev_dq_oe  = mem_dq_oe;
         prev_cs_low = !mem_cs_n;
         prev_addr   = mem_addr;
      end
   end

   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
      int n;
      logic [7:0] e;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      check(!req_ready, "R7", req_ready, 0);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_wdata = ~d;
      n = 1;
      while (!(rd_valid || wr_done) && n < 40) begin
         @(negedge clk);
         n++;
      end
      if (wr) begin
         check(wr_done && !rd_valid && n == WR_CYC + 1, "R5", n, WR_CYC + 1);
         exp_mem[int'(a)] = d;
      end else begin
         check(rd_valid && !wr_done && n == RD_CYC + 1, "R3", n, RD_CYC + 1);
         e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(a);
         check(rd_data == e, "R2", rd_data, e);
         @(negedge clk);
         check(!rd_valid, "R3", rd_valid, 0);
         if (!req_ready) begin
            // stay on schedule for the next request: it is held until ready
         end
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid && !wr_done,
            "R1", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      do_op(1'b0, 15'h1234, 8'h00);     // never-written byte
      do_op(1'b1, 15'h7FFF, 8'hA5);     // top address
      do_op(1'b0, 15'h7FFF, 8'h00);
      do_op(1'b1, 15'h0000, 8'h3C);     // read -> write, no idle gap (R6)
      do_op(1'b0, 15'h0000, 8'h00);
      do_op(1'b1, 15'h0000, 8'hC3);     // overwrite
      do_op(1'b0, 15'h0000, 8'h00);
      do_op(1'b0, 15'h7FFF, 8'h00);     // read -> read

      // seeded random mix
      for (int i = 0; i < 300; i++) begin
         int unsigned r;
         r = $urandom;
         do_op(r[8], pick_addr(int'(r[3:0])), r[23:16]);
         if (r[30]) repeat (int'(r[27:26])) @(negedge clk);
      end

      repeat (4) @(negedge clk);
      check(req_ready && mem_cs_n && !mem_dq_oe, "R1", {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule